// File: doc/BRIEF.md
# Configurable registered address/command buffer

This block is the register stage of a memory-module address and command path. On every rising clock edge it captures a 25-bit input word and drives it onto 28 registered output lanes. Two static configuration pins pick one of three lane arrangements. The first is a wide one-to-one arrangement. The other two fan out the low 14 input bits, each to two output lanes, and differ only in which lanes receive each copy.

Two active-low chip selects are captured at the same edge as the data and brought out on their own outputs. When both are sampled high, the captured word is not updated and the data outputs keep their previous values. An active-low asynchronous reset clears every register and forces all outputs low, whatever the chip selects are doing. The configuration pins are sampled only on clock edges that fall inside reset, so a new arrangement takes effect when reset is released.

Top module: `regbuf_top`

## Requirements
- R1: With cfg_fan_i sampled low (one-to-one mode), q_o[k] equals the registered d_i[k] for k from 0 to 24, and q_o[27:25] is 0.
- R2: With cfg_fan_i sampled high and cfg_map_i sampled low (mapping A), q_o[k] and q_o[k+14] both equal the registered d_i[k] for k from 0 to 13.
- R3: With cfg_fan_i and cfg_map_i both sampled high (mapping B), q_o[2k] and q_o[2k+1] both equal the registered d_i[k] for k from 0 to 13.
- R4: Data are captured on the rising edge of clk_i and appear on q_o after that edge, one edge of latency.
- R5: While rst_ni is low, q_o and qcs_o are all zero, and they go to zero at once when rst_ni falls, without waiting for a clock edge.
- R6: When dcs_ni and csr_ni are both high at a rising edge, q_o keeps the value it had before that edge.
- R7: When either dcs_ni or csr_ni is low at a rising edge, q_o takes the new data from that edge.
- R8: With csr_ni held low, every rising edge updates q_o, whatever dcs_ni does.
- R9: Reset dominates the chip selects: with both selects high, asserting rst_ni still forces q_o to zero.
- R10: After reset is released with d_i held at zero, q_o stays zero on every following edge.
- R11: cfg_fan_i and cfg_map_i are sampled only on rising edges while rst_ni is low; changes on them while out of reset have no effect on q_o until the next reset.
- R12: qcs_o[0] is the registered dcs_ni and qcs_o[1] is the registered csr_ni, updated on every rising edge out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Capture clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_fan_i | input | 1 | Mode: 0 one-to-one, 1 one-to-two fan-out |
| cfg_map_i | input | 1 | Fan-out mapping: 0 mapping A, 1 mapping B |
| dcs_ni | input | 1 | First chip select, active low |
| csr_ni | input | 1 | Second chip select, active low |
| d_i | input | 25 | Data inputs |
| q_o | output | 28 | Registered data lanes |
| qcs_o | output | 2 | Registered chip selects {csr, dcs} |

## Verification
Random data words are driven under each of the three lane arrangements, so that a lane taking its bit from the wrong source shows up as a mismatch on some cycle. The chip selects are stepped through all four combinations, and then csr_ni is held low while dcs_ni toggles. This separates a hold gated on either select from a hold gated on both. A reset that falls between clock edges while both selects are high shows whether the clear is asynchronous and whether it overrides the gating. Changing the configuration pins in mid-run shows whether they are latched only while reset is held.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;
  localparam int unsigned DATA_W = 25;
  localparam int unsigned LANE_W = 14;
  localparam int unsigned OUT_W  = 2 * LANE_W;
  localparam int unsigned CS_W   = 2;

  typedef enum logic [1:0] {
    MODE_1X1  = 2'd0,
    MODE_2X_A = 2'd1,
    MODE_2X_B = 2'd2
  } fan_mode_e;
endpackage

// File: rtl/regbuf_cfg_latch.sv
module regbuf_cfg_latch
  import regbuf_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      fan_i,
  input  logic      map_i,
  output fan_mode_e mode_o
);
  logic fan_q, map_q;

  // config is only loaded while reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      fan_q <= fan_i;
      map_q <= map_i;
    end
  end

  always_comb begin
    if (!fan_q)     mode_o = MODE_1X1;
    else if (map_q) mode_o = MODE_2X_B;
    else            mode_o = MODE_2X_A;
  end
endmodule

// File: rtl/regbuf_capture.sv
module regbuf_capture #(
  parameter int unsigned DATA_W = 25,
  parameter int unsigned CS_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] d_i,
  input  logic              dcs_ni,
  input  logic              csr_ni,
  output logic [DATA_W-1:0] data_o,
  output logic [CS_W-1:0]   cs_o
);
  logic load;
  assign load = ~(dcs_ni & csr_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      cs_o   <= '0;
    end else begin
      cs_o <= {csr_ni, dcs_ni};
      if (load) data_o <= d_i;
    end
  end
endmodule

// File: rtl/regbuf_fanout.sv
module regbuf_fanout
  import regbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 25,
  parameter int unsigned LANE_W = 14,
  parameter int unsigned OUT_W  = 2 * LANE_W
) (
  input  fan_mode_e         mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [OUT_W-1:0]  q_o
);
  for (genvar o = 0; o < OUT_W; o++) begin : g_bit
    logic one_b, a_b, b_b;

    if (o < DATA_W) begin : g_one
      assign one_b = data_i[o];
    end else begin : g_one_pad
      assign one_b = 1'b0;
    end

    if (o < 2 * LANE_W) begin : g_two
      assign a_b = data_i[o % LANE_W];
      assign b_b = data_i[o / 2];
    end else begin : g_two_pad
      assign a_b = 1'b0;
      assign b_b = 1'b0;
    end

    always_comb begin
      unique case (mode_i)
        MODE_2X_A: q_o[o] = a_b;
        MODE_2X_B: q_o[o] = b_b;
        default:   q_o[o] = one_b;
      endcase
    end
  end
endmodule

// File: rtl/regbuf_top.sv
module regbuf_top
  import regbuf_pkg::*;
#(
  parameter int unsigned D_W  = DATA_W,
  parameter int unsigned L_W  = LANE_W,
  localparam int unsigned Q_W = 2 * L_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cfg_fan_i,
  input  logic           cfg_map_i,
  input  logic           dcs_ni,
  input  logic           csr_ni,
  input  logic [D_W-1:0] d_i,
  output logic [Q_W-1:0] q_o,
  output logic [1:0]     qcs_o
);
  fan_mode_e      mode;
  logic [D_W-1:0] data_q;

  regbuf_cfg_latch u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fan_i  (cfg_fan_i),
    .map_i  (cfg_map_i),
    .mode_o (mode)
  );

  regbuf_capture #(.DATA_W(D_W), .CS_W(2)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (d_i),
    .dcs_ni (dcs_ni),
    .csr_ni (csr_ni),
    .data_o (data_q),
    .cs_o   (qcs_o)
  );

  regbuf_fanout #(.DATA_W(D_W), .LANE_W(L_W), .OUT_W(Q_W)) u_fan (
    .mode_i (mode),
    .data_i (data_q),
    .q_o    (q_o)
  );
endmodule

// File: rtl/regbuf_sva.sv
module regbuf_sva
  import regbuf_pkg::*;
#(
  parameter int unsigned D_W = 25,
  parameter int unsigned L_W = 14,
  parameter int unsigned Q_W = 28
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           dcs_ni,
  input logic           csr_ni,
  input logic [D_W-1:0] d_i,
  input logic [Q_W-1:0] q_o,
  input logic [1:0]     qcs_o,
  input fan_mode_e      mode
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  p_reset_low_r5: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0 && qcs_o == '0));

  p_one_to_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && mode == MODE_1X1 && qcs_o != 2'b11) |-> q_o[D_W-1:0] == $past(d_i));

  p_pad_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_1X1) |-> q_o[Q_W-1:D_W] == '0);

  p_dup_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_2X_A) |-> q_o[L_W-1:0] == q_o[Q_W-1:L_W]);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && qcs_o == 2'b11) |-> q_o == $past(q_o));

  p_cs_reg_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> qcs_o == $past({csr_ni, dcs_ni}));
endmodule

bind regbuf_top regbuf_sva #(.D_W(D_W), .L_W(L_W), .Q_W(Q_W)) u_sva (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .dcs_ni (dcs_ni),
  .csr_ni (csr_ni),
  .d_i    (d_i),
  .q_o    (q_o),
  .qcs_o  (qcs_o),
  .mode   (mode)
);

// File: tb/regbuf_top_test.sv
`timescale 1ns/1ps
module regbuf_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        c_fan = 1'b0, c_map = 1'b0;
  logic        dcs_n = 1'b1, csr_n = 1'b1;
  logic [24:0] d = '0;
  logic [27:0] q;
  logic [1:0]  qcs;

  int checks = 0, errors = 0;

  // reference state
  logic [24:0] m_data = '0;
  logic [1:0]  m_cs = '0;
  logic        m_fan = 1'b0, m_map = 1'b0;

  always #4 clk = ~clk;

  regbuf_top uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_fan_i(c_fan), .cfg_map_i(c_map),
    .dcs_ni(dcs_n), .csr_ni(csr_n), .d_i(d), .q_o(q), .qcs_o(qcs)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = '0;
      m_cs   = '0;
    end else begin
      m_cs = {csr_n, dcs_n};
      if (!(dcs_n && csr_n)) m_data = d;
    end
  end

  always @(posedge clk) if (!rst_n) begin
    m_fan = c_fan;
    m_map = c_map;
  end

  function automatic logic [27:0] expect_q();
    logic [27:0] e;
    for (int k = 0; k < 28; k++) begin
      if (!m_fan)      e[k] = (k < 25) ? m_data[k] : 1'b0;
      else if (!m_map) e[k] = m_data[k % 14];
      else             e[k] = m_data[k / 2];
    end
    return e;
  endfunction

  task automatic check(string req);
    logic [27:0] e;
    e = (rst_n === 1'b0) ? '0 : expect_q();
    checks++;
    if (q !== e) begin
      errors++;
      $display("FAIL %s q actual=%h expected=%h", req, q, e);
    end
    checks++;
    if (qcs !== m_cs) begin
      errors++;
      $display("FAIL R12 qcs actual=%b expected=%b", qcs, m_cs);
    end
  endtask

  task automatic step(string req, logic [24:0] dv, logic dcs, logic csr);
    @(negedge clk);
    check(req);
    d = dv; dcs_n = dcs; csr_n = csr;
  endtask

  task automatic do_reset(logic fan, logic map);
    @(negedge clk);
    #1 rst_n = 1'b0;
    c_fan = fan; c_map = map;
    d = '0; dcs_n = 1'b0; csr_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R5");
    end
    rst_n = 1'b1;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    do_reset(1'b0, 1'b0);
    // R10: quiet release
    for (int i = 0; i < 4; i++) step("R10", '0, 1'b0, 1'b1);
    // R1/R4/R7: one-to-one, each select alone
    for (int i = 0; i < 20; i++) step("R1", 25'($urandom), 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) step("R7", 25'($urandom), 1'b1, 1'b0);
    for (int i = 0; i < 10; i++) step("R4", 25'($urandom), 1'b0, 1'b0);
    // R6: both high holds
    for (int i = 0; i < 15; i++) step("R6", 25'($urandom), 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) step("R6", 25'($urandom), i[0], i[1]);
    // R8: csr tied low
    for (int i = 0; i < 20; i++) step("R8", 25'($urandom), i[0], 1'b0);
    // R11: config change while running is ignored
    @(negedge clk); c_fan = 1'b1; c_map = 1'b1;
    for (int i = 0; i < 15; i++) step("R11", 25'($urandom), 1'b0, 1'b1);
    // R9/R5: asynchronous reset mid-cycle with both selects high
    step("R6", 25'($urandom), 1'b1, 1'b1);
    @(posedge clk); #2 rst_n = 1'b0;
    #1 check("R9");
    @(negedge clk); check("R5");
    rst_n = 1'b1;
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 30; i++) step("R2", 25'($urandom), i[2], i[0]);
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 30; i++) step("R3", 25'($urandom), i[1], i[2]);
    for (int i = 0; i < 10; i++) step("R6", 25'($urandom), 1'b1, 1'b1);
    step("R3", '0, 1'b0, 1'b0);
    @(negedge clk); check("R3");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL R4 watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule